// File: doc/BRIEF.md
# Prescaled Timer Channel with Match Comparators

A single free-running 16-bit timer channel. Each count tick comes from the system clock, either directly or through a power-of-two prescaler. Once enabled, the channel counts until it is disabled, and no event stops it.

The count can run up or down. It wraps either over the full 16-bit range or over a programmable period of interval plus one. Three independent comparators each fire a one-cycle pulse when the count reaches their value, and counting carries on past the match. A surrounding register file supplies the control fields and turns the pulses into latched status.

Control fields:
- Counter control (5 bits):
  - bit 0 disables counting.
  - bit 1 selects interval wrap.
  - bit 2 selects count-down.
  - bit 3 enables the match comparators.
  - bit 4 is a synchronous counter clear.
- Clock control (5 bits):
  - bit 0 enables the prescaler.
  - bits 4:1 hold the exponent N.

Top module: `tmr_chan`

## Requirements
- R1: While rst_ni is low, count_o is 0 and every event output is 0.
- R2: When enabled (counter control bit 0 = 0) with the prescaler off (clock control bit 0 = 0), the count changes by one on every clock.
- R3: While counter control bit 0 is 1, the count holds and no events fire. Clearing the bit resumes counting from the held value.
- R4: While counter control bit 4 is 1, the count returns to 0 on the next clock and the prescaler phase restarts. No event fires.
- R5: Counting up with counter control bit 1 = 0, the count wraps from 0xFFFF to 0. In that cycle ovf_evt_o pulses.
- R6: With counter control bit 1 = 1, the period is interval_i + 1. Counting up, the count wraps from a value at or above interval_i to 0, and intv_evt_o (not ovf_evt_o) pulses.
- R7: With counter control bit 2 = 1, the count decrements. From 0 it wraps to 0xFFFF in overflow mode, or to interval_i in interval mode, with the matching wrap pulse.
- R8: With counter control bit 3 = 1, match_evt_o[k] pulses for one cycle when the count becomes equal to match value k. Match value k occupies bits 16k+15:16k of match_i. Counting continues. With bit 3 = 0, no match pulse fires.
- R9: With the prescaler on and exponent N, the count advances once every 2^(N+1) clocks.
- R10: Every event pulse is high in the same cycle as the count value that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ctrl_i | input | 5 | Bit 0 prescaler enable, bits 4:1 exponent N |
| cnt_ctrl_i | input | 5 | Bit 0 disable, 1 interval mode, 2 down, 3 match enable, 4 clear |
| interval_i | input | 16 | Interval wrap value |
| match_i | input | 48 | Three match values, value k at bits 16k+15:16k |
| count_o | output | 16 | Current count |
| intv_evt_o | output | 1 | Interval-mode wrap pulse |
| ovf_evt_o | output | 1 | Overflow-mode wrap pulse |
| match_evt_o | output | 3 | Per-comparator match pulses |

## Verification
The count and all event pulses are registers, each updated at the clock edge where the prescaler tick is active. A change on the control inputs therefore shows at the outputs exactly one clock later, together with its event. The bench drives inputs and samples outputs at the falling edge. Its behavioural model advances at the rising edge, so every comparison sees the result of the edge just before it. Directed checks count rising edges from a known clear to fix the exact expected count and pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic clr;
    logic match_en;
    logic down;
    logic intv_mode;
    logic dis;
  } cnt_ctrl_t;

  typedef struct packed {
    logic [3:0] div_exp;
    logic       pre_en;
  } clk_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             pre_en_i,
  input  logic [EXP_W-1:0] div_exp_i,
  output logic             tick_o
);
  localparam int PRE_W = 1 << EXP_W;
  localparam logic [PRE_W-1:0] ONES = '1;
  localparam logic [EXP_W-1:0] TOP_SH = EXP_W'(PRE_W - 1);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] lim;
  logic             hit;

  // last phase of a 2^(N+1) cycle
  assign lim    = ONES >> (TOP_SH - div_exp_i);
  assign hit    = pre_q >= lim;
  assign tick_o = run_i & (~pre_en_i | hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (clr_i)     pre_q <= '0;
    else if (!pre_en_i) pre_q <= '0;
    else if (run_i)     pre_q <= hit ? '0 : pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic             down_i,
  input  logic             intv_mode_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_nxt_o,
  output logic             intv_evt_o,
  output logic             ovf_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;
  logic             intv_q, ovf_q;

  assign top = intv_mode_i ? interval_i : '1;

  always_comb begin
    wrap    = 1'b0;
    cnt_nxt = cnt_q;
    if (down_i) begin
      if (cnt_q == '0) begin
        wrap    = 1'b1;
        cnt_nxt = top;
      end else begin
        cnt_nxt = cnt_q - CNT_W'(1);
      end
    end else begin
      // >= catches an interval lowered below the count
      if (cnt_q >= top) begin
        wrap    = 1'b1;
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      intv_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      intv_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      intv_q <= tick_i & wrap & intv_mode_i;
      ovf_q  <= tick_i & wrap & ~intv_mode_i;
      if (tick_i) cnt_q <= cnt_nxt;
    end
  end

  assign count_o     = cnt_q;
  assign count_nxt_o = cnt_nxt;
  assign intv_evt_o  = intv_q;
  assign ovf_evt_o   = ovf_q;
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int CNT_W   = 16,
  parameter int N_MATCH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     tick_i,
  input  logic                     en_i,
  input  logic [CNT_W-1:0]         count_nxt_i,
  input  logic [N_MATCH*CNT_W-1:0] match_i,
  output logic [N_MATCH-1:0]       evt_o
);
  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    logic evt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     evt_q <= 1'b0;
      else if (clr_i)  evt_q <= 1'b0;
      else             evt_q <= tick_i & en_i &
                                (count_nxt_i == match_i[k*CNT_W +: CNT_W]);
    end
    assign evt_o[k] = evt_q;
  end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int CNT_W   = 16,
  parameter int EXP_W   = 4,
  parameter int N_MATCH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [EXP_W:0]           clk_ctrl_i,
  input  logic [4:0]               cnt_ctrl_i,
  input  logic [CNT_W-1:0]         interval_i,
  input  logic [N_MATCH*CNT_W-1:0] match_i,
  output logic [CNT_W-1:0]         count_o,
  output logic                     intv_evt_o,
  output logic                     ovf_evt_o,
  output logic [N_MATCH-1:0]       match_evt_o
);
  import tmr_pkg::*;

  cnt_ctrl_t        cc;
  logic             run, tick;
  logic [CNT_W-1:0] count_nxt;

  assign cc  = cnt_ctrl_t'(cnt_ctrl_i);
  assign run = ~cc.dis & ~cc.clr;

  tmr_prescaler #(.EXP_W(EXP_W)) i_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (cc.clr),
    .run_i    (run),
    .pre_en_i (clk_ctrl_i[0]),
    .div_exp_i(clk_ctrl_i[EXP_W:1]),
    .tick_o   (tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cc.clr),
    .tick_i     (tick),
    .down_i     (cc.down),
    .intv_mode_i(cc.intv_mode),
    .interval_i (interval_i),
    .count_o    (count_o),
    .count_nxt_o(count_nxt),
    .intv_evt_o (intv_evt_o),
    .ovf_evt_o  (ovf_evt_o)
  );

  tmr_match #(.CNT_W(CNT_W), .N_MATCH(N_MATCH)) i_match (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (cc.clr),
    .tick_i     (tick),
    .en_i       (cc.match_en),
    .count_nxt_i(count_nxt),
    .match_i    (match_i),
    .evt_o      (match_evt_o)
  );
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int CNT_W   = 16,
  parameter int EXP_W   = 4,
  parameter int N_MATCH = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [EXP_W:0]           clk_ctrl_i,
  input logic [4:0]               cnt_ctrl_i,
  input logic [CNT_W-1:0]         interval_i,
  input logic [N_MATCH*CNT_W-1:0] match_i,
  input logic [CNT_W-1:0]         count_o,
  input logic                     intv_evt_o,
  input logic                     ovf_evt_o,
  input logic [N_MATCH-1:0]       match_evt_o
);
  // R1
  always_comb
    if (!rst_ni) reset_zero_chk: assert (count_o == '0 && !intv_evt_o && !ovf_evt_o && match_evt_o == '0);

  // R2
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ctrl_i[4:0] == 5'b00000 && !clk_ctrl_i[0] && count_o != '1)
      |=> count_o == $past(count_o) + CNT_W'(1));

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_ctrl_i[0] && !cnt_ctrl_i[4]) |=> ($stable(count_o) && !intv_evt_o && !ovf_evt_o));

  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_ctrl_i[4] |=> (count_o == '0 && match_evt_o == '0));

  // R5
  ovf_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_o |-> (count_o == '0 || count_o == '1));

  // R6
  wrap_kind_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({intv_evt_o, ovf_evt_o}));

  // R8
  match_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_ctrl_i[3] |=> match_evt_o == '0);

  // R10
  match_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_evt_o[0] |-> count_o == $past(match_i[CNT_W-1:0]));
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W), .EXP_W(EXP_W), .N_MATCH(N_MATCH)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_ctrl_i(clk_ctrl_i), .cnt_ctrl_i(cnt_ctrl_i),
  .interval_i(interval_i), .match_i(match_i), .count_o(count_o),
  .intv_evt_o(intv_evt_o), .ovf_evt_o(ovf_evt_o), .match_evt_o(match_evt_o)
);

// File: tb/test_tmr_chan.sv
module test_tmr_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  clk_ctrl = '0;
  logic [4:0]  cnt_ctrl = 5'b00001;
  logic [15:0] interval = '0;
  logic [15:0] m0 = '0, m1 = '0, m2 = '0;
  logic [15:0] count;
  logic        intv_evt, ovf_evt;
  logic [2:0]  match_evt;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt = 0, m_pre = 0;
  bit m_iv = 0, m_ov = 0;
  bit [2:0] m_mt = '0;

  always #4 clk = ~clk;

  tmr_chan i_tmr_chan (
    .clk_i(clk), .rst_ni(rst_n), .clk_ctrl_i(clk_ctrl), .cnt_ctrl_i(cnt_ctrl),
    .interval_i(interval), .match_i({m2, m1, m0}), .count_o(count),
    .intv_evt_o(intv_evt), .ovf_evt_o(ovf_evt), .match_evt_o(match_evt)
  );

  always @(posedge clk) begin
    int rate, top, mv[3];
    bit tick, wrap;
    cycles++;
    m_iv = 0; m_ov = 0; m_mt = '0;
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0;
    end else if (cnt_ctrl[4]) begin
      m_cnt = 0; m_pre = 0;
    end else if (!cnt_ctrl[0]) begin
      rate = 1 << (int'(clk_ctrl[4:1]) + 1);
      if (!clk_ctrl[0]) begin tick = 1; m_pre = 0; end
      else if (m_pre >= rate - 1) begin tick = 1; m_pre = 0; end
      else begin tick = 0; m_pre++; end
      if (tick) begin
        top = cnt_ctrl[1] ? int'(interval) : 65535;
        wrap = 0;
        if (cnt_ctrl[2]) begin
          if (m_cnt == 0) begin m_cnt = top; wrap = 1; end else m_cnt--;
        end else begin
          if (m_cnt >= top) begin m_cnt = 0; wrap = 1; end else m_cnt++;
        end
        if (wrap) begin
          if (cnt_ctrl[1]) m_iv = 1; else m_ov = 1;
        end
        mv[0] = m0; mv[1] = m1; mv[2] = m2;
        if (cnt_ctrl[3])
          for (int k = 0; k < 3; k++) if (m_cnt == mv[k]) m_mt[k] = 1;
      end
    end else if (!clk_ctrl[0]) m_pre = 0;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // one clock: sample against the model at the falling edge
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, {count, intv_evt, ovf_evt, match_evt}, {m_cnt[15:0], m_iv, m_ov, m_mt});
    end
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finish();
  end

  initial begin
    tag = "R1";
    step(3);
    chk("R1", {count, intv_evt, ovf_evt, match_evt}, 0);
    rst_n = 1'b1;
    cnt_ctrl = 5'b00000;
    tag = "R2"; step(20);
    chk("R2", count, 20);
    cnt_ctrl = 5'b00001; tag = "R3"; step(10);
    chk("R3", count, 20);
    cnt_ctrl = 5'b00000; step(5);
    chk("R3", count, 25);
    cnt_ctrl = 5'b10000; tag = "R4"; step(1);
    chk("R4", count, 0);
    cnt_ctrl = 5'b00000; tag = "R5"; step(65536);
    chk("R5", {count, ovf_evt}, {16'h0, 1'b1});
    interval = 16'd5;
    cnt_ctrl = 5'b10010; tag = "R6"; step(1);
    cnt_ctrl = 5'b00010; step(6);
    chk("R6", {count, intv_evt, ovf_evt}, {16'h0, 1'b1, 1'b0});
    step(14);
    cnt_ctrl = 5'b10000; tag = "R7"; step(1);
    cnt_ctrl = 5'b00100; step(1);
    chk("R7", {count, ovf_evt}, {16'hFFFF, 1'b1});
    step(5);
    cnt_ctrl = 5'b10100; step(1);
    cnt_ctrl = 5'b00110; step(1);
    chk("R7", {count, intv_evt}, {16'd5, 1'b1});
    step(15);
    interval = 16'd9; m0 = 16'd3; m1 = 16'd7; m2 = 16'd0;
    cnt_ctrl = 5'b11010; tag = "R8"; step(1);
    cnt_ctrl = 5'b01010; step(3);
    chk("R10", {count, match_evt}, {16'd3, 3'b001});
    step(1);
    chk("R8", {count, match_evt}, {16'd4, 3'b000});
    step(3);
    chk("R8", {count, match_evt}, {16'd7, 3'b010});
    step(3);
    chk("R8", {count, intv_evt, match_evt}, {16'd0, 1'b1, 3'b100});
    cnt_ctrl = 5'b00010; step(25);
    cnt_ctrl = 5'b11110; step(40);
    clk_ctrl = 5'b00011;
    cnt_ctrl = 5'b10000; tag = "R9"; step(1);
    cnt_ctrl = 5'b00000; step(8);
    chk("R9", count, 2);
    clk_ctrl = 5'b00001; step(20);
    clk_ctrl = 5'b00101; step(40);
    tag = "R10";
    for (int r = 0; r < 300; r++) begin
      cnt_ctrl = 5'($urandom_range(0, 15));
      if ($urandom_range(0, 9) == 0) cnt_ctrl[4] = 1'b1;
      clk_ctrl = {2'b00, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1))};
      interval = 16'($urandom_range(0, 12));
      m0 = 16'($urandom_range(0, 12));
      m1 = 16'($urandom_range(0, 12));
      m2 = 16'($urandom_range(0, 12));
      step(int'($urandom_range(1, 20)));
    end
    finish();
  end
endmodule